// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter of parameterised width, four bits by default. On each rising clock edge it can load a parallel word, step up or down by one with wraparound, or hold its value. All state bits change on the same edge. Loading takes priority over counting. Counting needs two active-low enables, both asserted at once. The direction input selects whether the count goes up or down.

The active-low terminal-count output marks the last value before wraparound in the current direction: all ones when counting up, all zeros when counting down. It is decoded from the register through combinational logic and is gated only by the trickle enable. Several counters can therefore be chained into a wider counter with no extra logic: each stage's terminal count drives the trickle enable of the next stage, and all stages share the clock, the load, the direction and the parallel enable. An active-high synchronous clear is included as a test convenience.

Top module: `updn_counter`

## Requirements
- R1: When `srst` is high at a rising edge, `count` becomes 0, whatever the other inputs are, including a low `load_n`.
- R2: When `srst` is low and `load_n` is low at a rising edge, `count` takes the value of `din`, whatever the levels of both count enables and `dir_up`.
- R3: The counter advances only when `load_n` is high and `en_par_n` and `en_trk_n` are both low.
- R4: When it advances with `dir_up` = 1, `count` increases by one and wraps from all ones (15) to 0.
- R5: When it advances with `dir_up` = 0, `count` decreases by one and wraps from 0 to all ones (15).
- R6: When `load_n` is high and either `en_par_n` or `en_trk_n` is high, `count` keeps its value.
- R7: `tc_n` is low exactly when `en_trk_n` is low and either `dir_up` = 1 with `count` all ones, or `dir_up` = 0 with `count` = 0. Otherwise it is high. `en_par_n` has no effect on `tc_n`.
- R8: `tc_n` follows changes on `dir_up` and `en_trk_n` within the same clock cycle, with no clock edge in between.
- R9: Two stages chained as described above (low stage `tc_n` into the high stage `en_trk_n`, shared `load_n`, `en_par_n`, `dir_up` and clock) behave as one 8-bit counter. It wraps from 255 to 0 counting up and from 0 to 255 counting down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| srst | input | 1 | Synchronous clear, active high; outranks load |
| load_n | input | 1 | Parallel load, active low |
| en_par_n | input | 1 | Parallel count enable, active low; does not gate `tc_n` |
| en_trk_n | input | 1 | Trickle count enable, active low; also gates `tc_n` |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| din | input | WIDTH | Parallel load data |
| count | output | WIDTH | Current counter value |
| tc_n | output | 1 | Terminal count, active low, combinational |

## Verification
A wrong next-state value shows on `count` one edge after the faulty step. Because every later value builds on it, the error stays visible for as long as the counter keeps running. A wrong terminal-count decode shows on `tc_n` within the same cycle, but only while the count sits at a terminal value or while the enables or direction change there. A chained pair magnifies a faulty terminal count: the high stage steps on the wrong edge and the 8-bit value is off by 16 from that point on. Walking the stages through both wraps shows the fault within one pass.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STEP  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_op_sel.sv
module cnt_op_sel
  import cnt_pkg::*;
(
  input  logic    srst,
  input  logic    load_n,
  input  logic    en_par_n,
  input  logic    en_trk_n,
  output cnt_op_e op
);
  // priority: clear, then load, then step, else hold
  always_comb begin
    if (srst)                       op = OP_CLEAR;
    else if (!load_n)               op = OP_LOAD;
    else if (!en_par_n && !en_trk_n) op = OP_STEP;
    else                            op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op,
  input  logic             dir_up,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  // one adder: +1 or +all-ones (i.e. -1), wrap is natural modulo 2**WIDTH
  logic [WIDTH-1:0] delta;
  assign delta = dir_up ? WIDTH'(1) : {WIDTH{1'b1}};

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_STEP:  nxt = cur + delta;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_tc_dec.sv
module cnt_tc_dec #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             dir_up,
  input  logic             en_trk_n,
  output logic             tc_n
);
  logic at_top;
  logic at_bottom;
  assign at_top    = &cur;
  assign at_bottom = ~|cur;
  assign tc_n = ~(~en_trk_n & (dir_up ? at_top : at_bottom));
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             load_n,
  input  logic             en_par_n,
  input  logic             en_trk_n,
  input  logic             dir_up,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             tc_n
);
  cnt_op_e          op;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  cnt_op_sel u_op (
    .srst     (srst),
    .load_n   (load_n),
    .en_par_n (en_par_n),
    .en_trk_n (en_trk_n),
    .op       (op)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .op     (op),
    .dir_up (dir_up),
    .din    (din),
    .cur    (cnt_q),
    .nxt    (cnt_d)
  );

  always_ff @(posedge clk) cnt_q <= cnt_d;

  cnt_tc_dec #(.WIDTH(WIDTH)) u_tc (
    .cur      (cnt_q),
    .dir_up   (dir_up),
    .en_trk_n (en_trk_n),
    .tc_n     (tc_n)
  );

  assign count = cnt_q;
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             srst,
  input logic             load_n,
  input logic             en_par_n,
  input logic             en_trk_n,
  input logic             dir_up,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] count,
  input logic             tc_n
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
    srst |=> (count == '0));

  p_load_r2: assert property (@(posedge clk) disable iff (srst || !armed)
    !load_n |=> (count == $past(din)));

  p_up_r4: assert property (@(posedge clk) disable iff (srst || !armed)
    (load_n && !en_par_n && !en_trk_n && dir_up)
      |=> (count == WIDTH'($past(count) + WIDTH'(1))));

  p_down_r5: assert property (@(posedge clk) disable iff (srst || !armed)
    (load_n && !en_par_n && !en_trk_n && !dir_up)
      |=> (count == WIDTH'($past(count) - WIDTH'(1))));

  p_hold_r6: assert property (@(posedge clk) disable iff (srst || !armed)
    (load_n && (en_par_n || en_trk_n)) |=> $stable(count));

  p_tc_gate_r7: assert property (@(posedge clk) disable iff (srst || !armed)
    !tc_n |-> !en_trk_n);

  p_tc_top_r7: assert property (@(posedge clk) disable iff (srst || !armed)
    (!en_trk_n && dir_up && (&count)) |-> !tc_n);

  p_tc_bottom_r7: assert property (@(posedge clk) disable iff (srst || !armed)
    (!en_trk_n && !dir_up && (count == '0)) |-> !tc_n);
endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .srst     (srst),
  .load_n   (load_n),
  .en_par_n (en_par_n),
  .en_trk_n (en_trk_n),
  .dir_up   (dir_up),
  .din      (din),
  .count    (count),
  .tc_n     (tc_n)
);

// File: tb/test_updn_counter.sv
module test_updn_counter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  // single stage under test
  logic       srst = 1'b0, load_n = 1'b1, en_par_n = 1'b1, en_trk_n = 1'b1, dir_up = 1'b1;
  logic [3:0] din = '0;
  logic [3:0] count;
  logic       tc_n;

  updn_counter #(.WIDTH(4)) i_updn_counter (
    .clk(clk), .srst(srst), .load_n(load_n), .en_par_n(en_par_n),
    .en_trk_n(en_trk_n), .dir_up(dir_up), .din(din), .count(count), .tc_n(tc_n)
  );

  // two chained stages (R9)
  logic       c_srst = 1'b0, c_load_n = 1'b1, c_par_n = 1'b1, c_trk_n = 1'b1, c_up = 1'b1;
  logic [7:0] c_din = '0;
  logic [3:0] lo_q, hi_q;
  logic       lo_tc_n, hi_tc_n;

  updn_counter #(.WIDTH(4)) i_stage_lo (
    .clk(clk), .srst(c_srst), .load_n(c_load_n), .en_par_n(c_par_n),
    .en_trk_n(c_trk_n), .dir_up(c_up), .din(c_din[3:0]), .count(lo_q), .tc_n(lo_tc_n)
  );
  updn_counter #(.WIDTH(4)) i_stage_hi (
    .clk(clk), .srst(c_srst), .load_n(c_load_n), .en_par_n(c_par_n),
    .en_trk_n(lo_tc_n), .dir_up(c_up), .din(c_din[7:4]), .count(hi_q), .tc_n(hi_tc_n)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       ld_n;
    logic       pe_n;
    logic       te_n;
    logic       up;
    logic [3:0] d;
    logic [3:0] q;
    logic       tcn;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,1'b1,4'd7, 4'd7, 1'b1},  // R2 load 7
    '{1'b1,1'b0,1'b0,1'b1,4'd0, 4'd8, 1'b1},  // R4 up
    '{1'b1,1'b0,1'b0,1'b1,4'd0, 4'd9, 1'b1},
    '{1'b1,1'b0,1'b0,1'b1,4'd0, 4'd10,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,4'd0, 4'd11,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,4'd0, 4'd12,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,4'd0, 4'd13,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,4'd0, 4'd14,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,4'd0, 4'd15,1'b0},  // R7 top
    '{1'b1,1'b0,1'b0,1'b1,4'd0, 4'd0, 1'b1},  // R4 wrap
    '{1'b1,1'b0,1'b0,1'b1,4'd0, 4'd1, 1'b1},
    '{1'b1,1'b0,1'b0,1'b1,4'd0, 4'd2, 1'b1},
    '{1'b1,1'b1,1'b0,1'b1,4'd9, 4'd2, 1'b1},  // R6 inhibit par
    '{1'b1,1'b0,1'b1,1'b1,4'd9, 4'd2, 1'b1},  // R3/R6 inhibit trk
    '{1'b1,1'b0,1'b0,1'b0,4'd0, 4'd1, 1'b1},  // R5 down
    '{1'b1,1'b0,1'b0,1'b0,4'd0, 4'd0, 1'b0},  // R7 bottom
    '{1'b1,1'b0,1'b0,1'b0,4'd0, 4'd15,1'b1},  // R5 wrap
    '{1'b1,1'b0,1'b0,1'b0,4'd0, 4'd14,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,4'd0, 4'd13,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,4'd0, 4'd12,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,4'd0, 4'd11,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,4'd0, 4'd0, 1'b1},  // R2 load beats enables
    '{1'b1,1'b1,1'b0,1'b0,4'd6, 4'd0, 1'b0},  // R7 par_n no effect
    '{1'b1,1'b1,1'b1,1'b0,4'd6, 4'd0, 1'b1},  // R7 trk gates
    '{1'b0,1'b1,1'b1,1'b1,4'd15,4'd15,1'b1},  // R2 load 15
    '{1'b1,1'b1,1'b0,1'b1,4'd3, 4'd15,1'b0},  // R7 top, par high
    '{1'b1,1'b0,1'b0,1'b0,4'd3, 4'd14,1'b1},  // R5 down from 15
    '{1'b0,1'b0,1'b0,1'b0,4'd15,4'd15,1'b1}   // R2 load while counting
  };

  initial begin
    int ref8;
    // R1 reset state, also beats a pending load
    @(negedge clk);
    srst = 1'b1; load_n = 1'b0; din = 4'd9; en_trk_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset clears", int'(count), 0);
    chk("R7 tc_n idle", int'(tc_n), 1);
    @(negedge clk);
    srst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load_n = VEC[i].ld_n; en_par_n = VEC[i].pe_n; en_trk_n = VEC[i].te_n;
      dir_up = VEC[i].up; din = VEC[i].d;
      @(posedge clk); #1;
      chk($sformatf("R3/R4/R5 vec %0d count", i), int'(count), int'(VEC[i].q));
      chk($sformatf("R7 vec %0d tc_n", i), int'(tc_n), int'(VEC[i].tcn));
    end

    // R8: tc_n reacts to dir_up and en_trk_n within a cycle (count held at 15)
    @(negedge clk);
    load_n = 1'b1; en_par_n = 1'b1; en_trk_n = 1'b0; dir_up = 1'b1;
    #0.5 chk("R8 tc low at top/up", int'(tc_n), 0);
    dir_up = 1'b0;
    #0.5 chk("R8 tc follows dir_up", int'(tc_n), 1);
    dir_up = 1'b1;
    #0.5 chk("R8 tc back low", int'(tc_n), 0);
    en_trk_n = 1'b1;
    #0.5 chk("R8 tc follows en_trk_n", int'(tc_n), 1);
    @(posedge clk); #1;
    chk("R6 hold after R8 probe", int'(count), 15);

    // R1 mid-run clear beats load and count
    @(negedge clk);
    srst = 1'b1; load_n = 1'b0; din = 4'd5; en_par_n = 1'b0; en_trk_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 clear over load", int'(count), 0);
    @(negedge clk);
    srst = 1'b0; load_n = 1'b1; en_par_n = 1'b1;

    // R9 chained 8-bit counter against a reference model
    @(negedge clk);
    c_load_n = 1'b0; c_din = 8'hF0; c_par_n = 1'b1; c_trk_n = 1'b1;
    ref8 = 8'hF0;
    @(posedge clk); #1;
    chk("R9 chain load", int'({hi_q, lo_q}), ref8);
    @(negedge clk);
    c_load_n = 1'b1; c_par_n = 1'b0; c_trk_n = 1'b0; c_up = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      ref8 = (ref8 + 1) & 8'hFF;
      chk("R9 chain up", int'({hi_q, lo_q}), ref8);
    end
    @(negedge clk);
    c_up = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); #1;
      ref8 = (ref8 + 255) & 8'hFF;
      chk("R9 chain down", int'({hi_q, lo_q}), ref8);
    end
    // park at 0 counting down: both stages flag terminal count
    @(negedge clk);
    c_load_n = 1'b0; c_din = 8'h00; c_par_n = 1'b1;
    @(posedge clk); #1;
    chk("R9 chain tc at 0 down", int'(hi_tc_n), 0);
    @(negedge clk);
    c_load_n = 1'b1; c_par_n = 1'b0;
    @(posedge clk); #1;
    chk("R9 chain wrap 0 to 255", int'({hi_q, lo_q}), 255);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule